// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the memory address for every beat of a four-beat burst. A load strobe captures a full external address and starts a new burst from it. A burst-enable strobe then steps through the remaining beats. Only the two lowest address bits move. The upper bits stay as they were loaded. The low bits follow one of two orders: a linear count that wraps inside the aligned four-word group, or an interleaved order in which the start value is XORed with the beat number.

In single-rate mode one beat is used per clock and each advance moves the burst on by one beat. In double-rate mode two data words move per clock, so the block presents a pair of addresses (the current beat and the one after it) and each advance moves on by two beats. The order and rate selections are captured together with the address on each load and hold for the whole burst. The two address outputs are driven from registers through a small amount of logic, so a load or advance sampled at one rising edge is visible right after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) `addr_a` is 0 and `addr_b` is 1. The captured order is interleaved and the captured rate is single.
- R2: When `ld` is high at a rising edge, `addr_a` equals the full `addr_in` sampled at that edge, and the burst beat count restarts at 0.
- R3: The upper bits `[ADDR_W-1:2]` of both outputs keep the value from the last load for as long as `ld` stays low.
- R4: When `adv` is high and `ld` low at a rising edge with single rate captured, the beat count advances by one.
- R5: With linear order captured (`lin_ord`=1 at load), the low two bits of `addr_a` are (start + beat) mod 4. The count wraps inside the four-word group without carrying into bit 2.
- R6: With interleaved order captured (`lin_ord`=0 at load), the low two bits of `addr_a` are start XOR beat.
- R7: `addr_b` always carries the beat following the one on `addr_a`, in the captured order.
- R8: In double rate (`dbl_rate`=1 at load), each advance moves the beat count by two. `addr_a` and `addr_b` then cover beats 0/1 and then beats 2/3.
- R9: When `ld` and `adv` are both high, the load takes effect and the advance is ignored.
- R10: When `ld` and `adv` are both low at a rising edge, both outputs hold their values.
- R11: `lin_ord` and `dbl_rate` are sampled only on a load. Changing them between loads has no effect on the outputs.
- R12: Advancing past beat 3 wraps the beat count back to beat 0, so the sequence repeats from the start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld | input | 1 | Load the external address and start a burst |
| adv | input | 1 | Advance to the next beat (or beat pair) |
| lin_ord | input | 1 | 1 = linear order, 0 = interleaved order; captured on load |
| dbl_rate | input | 1 | 1 = two beats per clock, 0 = one beat per clock; captured on load |
| addr_in | input | ADDR_W | External start address |
| addr_a | output | ADDR_W | Address of the current beat |
| addr_b | output | ADDR_W | Address of the following beat |

## Verification
Load and advance can both be requested at the same edge. The bench provokes this by raising `ld` and `adv` together in the middle of an advancing burst, with a new address whose low bits are non-zero. It then judges that the outputs show exactly the new address at beat 0 and no step. Order and rate selections also change while a burst is advancing. The bench checks that each beat still matches the mode captured at the last load. That covers both interleaved and linear orders, and both single and double rate.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;
  localparam int BEAT_W = 2;
  localparam int BURST_LEN = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_INTLV = 1'b0,
    ORD_LIN   = 1'b1
  } order_e;

  // Low address bits for a given beat of a burst that began at 'start'.
  function automatic beat_t order_map(input beat_t start, input beat_t beat,
                                      input order_e ord);
    beat_t r;
    if (ord == ORD_LIN) r = start + beat;
    else                r = start ^ beat;
    return r;
  endfunction

  // Beats consumed by one advance.
  function automatic beat_t beat_step(input logic dbl);
    return dbl ? beat_t'(2) : beat_t'(1);
  endfunction
endpackage

// File: rtl/bs_load_ctrl.sv
`timescale 1ns/1ps
module bs_load_ctrl
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              adv,
  input  logic              lin_ord,
  input  logic              dbl_rate,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output beat_t             start_q,
  output beat_t             beat_q,
  output order_e            ord_q,
  output logic              dbl_q,
  output logic              load_evt,
  output logic              adv_evt
);
  localparam int UP_W = ADDR_W - BEAT_W;

  // Load wins over advance.
  assign load_evt = ld;
  assign adv_evt  = adv && !ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_INTLV;
      dbl_q   <= 1'b0;
    end else if (load_evt) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
      beat_q  <= '0;
      ord_q   <= order_e'(lin_ord);
      dbl_q   <= dbl_rate;
    end else if (adv_evt) begin
      beat_q  <= beat_q + beat_step(dbl_q);
    end
  end

  // R9
  ld_beats_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && adv) |=> (beat_q == '0));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !dbl_q) |=> (beat_q == $past(beat_q) + beat_t'(1)));

  // R8
  double_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && dbl_q) |=> (beat_q == $past(beat_q) + beat_t'(2)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv) |=> $stable(beat_q));

  // R11
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(ord_q) && $stable(dbl_q) && $stable(start_q)));

  // R3
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (upper_q == $past(upper_q)));

  logic unused_up;
  assign unused_up = ^upper_q[UP_W-1:0] & 1'b0;
endmodule

// File: rtl/bs_order_gen.sv
`timescale 1ns/1ps
module bs_order_gen
  import burst_pkg::*;
#(
  parameter int LANES = 2
) (
  input  beat_t                    start,
  input  beat_t                    beat,
  input  order_e                   ord,
  output logic [LANES-1:0][BEAT_W-1:0] lane_low
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    beat_t lane_beat;
    assign lane_beat   = beat + beat_t'(i);
    assign lane_low[i] = order_map(start, lane_beat, ord);
  end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              adv,
  input  logic              lin_ord,
  input  logic              dbl_rate,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b
);
  localparam int UP_W  = ADDR_W - BEAT_W;
  localparam int LANES = 2;

  logic [UP_W-1:0] upper_q;
  beat_t           start_q;
  beat_t           beat_q;
  order_e          ord_q;
  logic            dbl_q;
  logic            load_evt;
  logic            adv_evt;
  logic [LANES-1:0][BEAT_W-1:0] lane_low;

  bs_load_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .adv      (adv),
    .lin_ord  (lin_ord),
    .dbl_rate (dbl_rate),
    .addr_in  (addr_in),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .ord_q    (ord_q),
    .dbl_q    (dbl_q),
    .load_evt (load_evt),
    .adv_evt  (adv_evt)
  );

  bs_order_gen #(.LANES(LANES)) u_order (
    .start    (start_q),
    .beat     (beat_q),
    .ord      (ord_q),
    .lane_low (lane_low)
  );

  assign addr_a = {upper_q, lane_low[0]};
  assign addr_b = {upper_q, lane_low[1]};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (addr_a == $past(addr_in)));

  // R12
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !dbl_q && beat_q == beat_t'(3)) |=> (addr_a[BEAT_W-1:0] == start_q));

  // R5
  lin_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_q == ORD_LIN) |-> (addr_b[BEAT_W-1:0] == beat_t'(addr_a[BEAT_W-1:0] + 2'd1)));

  // R7
  intlv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ord_q == ORD_INTLV && dbl_q) |-> (addr_b[BEAT_W-1:0] == (addr_a[BEAT_W-1:0] ^ 2'b01)));

  // R3
  pair_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_a[ADDR_W-1:BEAT_W] == addr_b[ADDR_W-1:BEAT_W]);
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld = 1'b0, adv = 1'b0, lin_ord = 1'b0, dbl_rate = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_a, addr_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side burst state
  logic [AW-3:0] m_up = '0;
  int            m_start = 0, m_beat = 0;
  bit            m_lin = 0, m_dbl = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ld(ld), .adv(adv), .lin_ord(lin_ord),
    .dbl_rate(dbl_rate), .addr_in(addr_in), .addr_a(addr_a), .addr_b(addr_b)
  );

  function automatic int low_of(int start, int beat, bit lin);
    int b = beat % 4;
    if (lin) return (start + b) % 4;
    return ((start / 2) ^ (b / 2)) * 2 + ((start % 2) ^ (b % 2));
  endfunction

  function automatic logic [AW-1:0] exp_addr(int lane);
    return {m_up, 2'(low_of(m_start, m_beat + lane, m_lin))};
  endfunction

  task automatic chk(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_pair(string tag);
    chk({tag, " addr_a"}, addr_a, exp_addr(0));
    chk({tag, " addr_b"}, addr_b, exp_addr(1));
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cyc(bit l, bit a, bit lin, bit dbl, logic [AW-1:0] ad);
    ld = l; adv = a; lin_ord = lin; dbl_rate = dbl; addr_in = ad;
    @(posedge clk);
    if (l) begin
      m_up = ad[AW-1:2]; m_start = int'(ad[1:0]); m_beat = 0; m_lin = lin; m_dbl = dbl;
    end else if (a) begin
      m_beat = (m_beat + (m_dbl ? 2 : 1)) % 4;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (2) @(negedge clk);
    m_up = '0; m_start = 0; m_beat = 0; m_lin = 0; m_dbl = 0;
    chk("R1 reset addr_a", addr_a, '0);
    chk("R1 reset addr_b", addr_b, 17'd1);
    rst_n = 1;
  endtask

  task automatic t_linear;
    cyc(1, 0, 1, 0, 17'h1A5B6);
    chk("R2 load", addr_a, 17'h1A5B6);
    chk_pair("R5 lin beat0");
    for (int i = 1; i < 4; i++) begin
      cyc(0, 1, 1, 0, '0);
      chk_pair($sformatf("R5 R4 lin beat%0d", i));
      chk("R3 upper", {addr_a[AW-1:2], 2'b00}, 17'h1A5B4);
    end
    cyc(0, 1, 1, 0, '0);
    chk("R12 wrap", addr_a, 17'h1A5B6);
  endtask

  task automatic t_interleave;
    cyc(1, 0, 0, 0, 17'h00F01);
    for (int i = 1; i < 4; i++) begin
      cyc(0, 1, 0, 0, '0);
      chk_pair($sformatf("R6 intlv beat%0d", i));
    end
    chk("R6 intlv beat3 value", addr_a, 17'h00F02);
  endtask

  task automatic t_double;
    cyc(1, 0, 1, 1, 17'h0C003);
    chk("R8 dbl linear pair0 a", addr_a, 17'h0C003);
    chk("R7 dbl linear pair0 b", addr_b, 17'h0C000);
    cyc(0, 1, 0, 0, '0);
    chk("R8 dbl linear pair1 a", addr_a, 17'h0C001);
    chk("R7 dbl linear pair1 b", addr_b, 17'h0C002);
    cyc(1, 0, 0, 1, 17'h12342);
    cyc(0, 1, 1, 0, '0);
    chk_pair("R8 dbl intlv pair1");
    chk("R8 dbl intlv value", addr_a, 17'h12340);
  endtask

  task automatic t_priority;
    cyc(1, 0, 1, 0, 17'h00010);
    cyc(0, 1, 1, 0, '0);
    cyc(1, 1, 0, 0, 17'h1FFFE);
    chk("R9 load wins", addr_a, 17'h1FFFE);
    chk_pair("R9 load wins pair");
  endtask

  task automatic t_hold;
    cyc(0, 1, 0, 0, '0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 1, 17'h0AAAA);
      chk_pair("R10 idle hold");
    end
  endtask

  task automatic t_mode_latch;
    cyc(1, 0, 0, 0, 17'h05555);
    cyc(0, 1, 1, 1, '0);
    chk_pair("R11 ignore selects beat1");
    chk("R11 still interleaved single", addr_a, 17'h05554);
    cyc(0, 1, 1, 1, '0);
    chk("R11 still single step", addr_a, 17'h05557);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_linear();
    t_interleave();
    t_double();
    t_priority();
    t_hold();
    t_mode_latch();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule